// File: doc/BRIEF.md
# Descriptor Queue Accumulator with Paced Interrupts

This block watches a window of up to 32 neighbouring hardware descriptor queues. It visits the queues in turn. From each queue that reports data it pops one descriptor pointer, tags it with the queue's position inside the window, and writes the tagged entry into one of two host-visible list buffers. The host is told that a buffer is ready through a level interrupt. The interrupt carries the buffer number and the number of entries in that buffer. Collection then moves on into the other buffer while the host drains the first. The host releases the buffer with a one-cycle acknowledge.

A buffer is handed to the host when it is full, or when a pacing timer expires while the buffer holds at least one entry. The delay is given in microseconds. A prescaler of `TICK_CYCLES` clock cycles makes one microsecond. Four pacing modes decide which event starts the timer:
- **Mode 0 (`PACE_FULL_ONLY`):** no timer.
- **Mode 1 (`PACE_SINCE_IRQ`):** the timer starts at the last hand-over, and also once after reset.
- **Mode 2 (`PACE_SINCE_FIRST`):** the timer starts at the first entry written into an empty list.
- **Mode 3 (`PACE_SINCE_LAST`):** the timer restarts at every new entry.

The controller is a three-state machine:
- **`ST_SCAN`:** a round-robin picker chooses the next non-empty queue.
  - Transition *pick* goes to `ST_POP` when a queue is found and the list has room.
  - Transition *full* goes to `ST_STALL` when the list holds `LIST_DEPTH` entries.
- **`ST_POP`:** the pop request is held until the queue acknowledges it.
  - Transition *popped* writes the entry and returns to `ST_SCAN`.
- **`ST_STALL`:** the machine waits until the full list is handed over.
  - Transition *drained* returns to `ST_SCAN`.

A hand-over moves the list into the interrupt registers and switches the write buffer. It can take place in any state, but never in the same cycle as a list write.

Top module: `desc_accumulator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irq`, `pop_req` and `lw_en` are 0.
- R2: At most one pop is outstanding at a time.
  - `pop_qnum` equals `cfg_base_q` plus the index of the selected queue.
  - `pop_req` and `pop_qnum` hold steady until `pop_ack`.
  - Queues are served round-robin, starting after the last popped index and beginning at index 0 after reset.
- R3: Each popped descriptor produces one list write in the cycle after `pop_ack`.
  - `lw_data[36:32]` holds the 5-bit queue index and `lw_data[31:0]` holds the descriptor.
  - `lw_idx` counts 0, 1, 2 … within the current buffer.
  - `lw_buf` names the current buffer. Buffer 0 is used first.
- R4: When a hand-over occurs, `irq` rises with `irq_buf` equal to the buffer just filled and `irq_cnt` equal to its entry count (never 0). The following writes go to the other buffer, starting at index 0. A list that reaches `LIST_DEPTH` (16) entries is handed over in the next cycle when no interrupt is pending.
- R5: `irq`, `irq_buf` and `irq_cnt` hold until `irq_ack`. `irq` is 0 in the cycle after the acknowledge.
- R6: If the current list is full while the previous interrupt is still unacknowledged, no pops take place. After the acknowledge, the full list is handed over and popping resumes.
- R7: In mode 0 an interrupt occurs only for a full list. A partly filled list stays in place indefinitely.
- R8: Mode 1 times the delay from the last hand-over, or from reset.
  - An expiry with an empty list raises no interrupt.
  - The first entry after such an expiry is handed over in the next cycle.
  - Otherwise the interrupt rises `D*TICK_CYCLES+2` cycles after the previous interrupt rose.
- R9: Mode 2 times the delay from the first entry written into an empty list. `irq` rises `D*TICK_CYCLES+2` cycles after that entry's `lw_en` cycle, whatever entries follow.
- R10: Mode 3 restarts the delay at every entry. `irq` rises `D*TICK_CYCLES+2` cycles after the last entry's `lw_en` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_q | input | QNUM_W | Queue number of window index 0 |
| cfg_mode | input | 2 | Pacing mode 0..3 |
| cfg_delay_us | input | DLY_W | Pacing delay in microseconds |
| q_nonempty | input | NUM_Q | One bit per queue in the window, set when the queue holds a descriptor |
| pop_req | output | 1 | Pop request to the queue named by pop_qnum |
| pop_qnum | output | QNUM_W | Absolute number of the queue being popped |
| pop_ack | input | 1 | Pop accepted; pop_desc is valid |
| pop_desc | input | DESC_W | Descriptor pointer returned by the pop |
| lw_en | output | 1 | List write strobe |
| lw_buf | output | 1 | Buffer being written |
| lw_idx | output | LIDX_W | Entry position in the buffer |
| lw_data | output | IDX_W+DESC_W | Queue index above descriptor pointer |
| irq | output | 1 | Buffer-ready interrupt (level) |
| irq_buf | output | 1 | Buffer handed to the host |
| irq_cnt | output | CNT_W | Number of entries in that buffer |
| irq_ack | input | 1 | Host releases the handed-over buffer |

## Verification
The bench targets these corner cases:

- **Round-robin pointer.** Three sparse queues are loaded. A picker that restarts at index 0 after every pop would drain queue 3 twice before it serves queue 7.
- **Two buffers full with no acknowledge.** A design that fails to stall would overwrite a buffer the host still owns. A design that forgets the held full list after the acknowledge would never raise the second interrupt.
- **Exact pacing distances in each mode.** The bench measures the cycles between list writes and interrupt edges:
  - Timing from the wrong event shifts the interrupt by the gap between two deliberately spaced entries.
  - An interrupt on an empty list shows up as a spurious edge during the idle stretch in mode 1.
- **Scoreboard under random traffic.** Random pop and acknowledge latencies run in three modes. The scoreboard catches a lost, duplicated or misfiled entry.

// File: rtl/desc_acc_pkg.sv
package desc_acc_pkg;

    typedef enum logic [1:0] {
        ST_SCAN  = 2'd0,
        ST_POP   = 2'd1,
        ST_STALL = 2'd2
    } acc_state_e;

    typedef enum logic [1:0] {
        PACE_FULL_ONLY   = 2'd0,
        PACE_SINCE_IRQ   = 2'd1,
        PACE_SINCE_FIRST = 2'd2,
        PACE_SINCE_LAST  = 2'd3
    } pace_mode_e;

endpackage

// File: rtl/desc_acc_rr.sv
module desc_acc_rr #(
    parameter int N = 32,
    parameter int W = 5
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] ptr,
    output logic         found,
    output logic [W-1:0] pick
);

    logic [W:0] cand;

    // Lowest rotation distance from ptr wins; loop runs downward so it overrides.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        cand  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            cand = {1'b0, ptr} + (W + 1)'(i);
            if (cand >= (W + 1)'(N)) begin
                cand = cand - (W + 1)'(N);
            end
            if (req[cand[W-1:0]]) begin
                found = 1'b1;
                pick  = cand[W-1:0];
            end
        end
    end

endmodule

// File: rtl/desc_acc_pacer.sv
module desc_acc_pacer #(
    parameter int TICK_CYCLES = 100,
    parameter int DLY_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [DLY_W-1:0] delay,
    output logic             armed,
    output logic             expired
);

    localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

    logic [PRE_W-1:0] pre;
    logic [DLY_W-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            expired <= 1'b0;
            pre     <= '0;
            tcnt    <= '0;
        end else if (start) begin
            armed   <= 1'b1;
            expired <= 1'b0;
            pre     <= '0;
            tcnt    <= '0;
        end else if (stop) begin
            armed   <= 1'b0;
            expired <= 1'b0;
        end else if (armed) begin
            if (tcnt == delay) begin
                expired <= 1'b1;
                armed   <= 1'b0;
            end else if (pre == PRE_LAST) begin
                pre  <= '0;
                tcnt <= tcnt + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    // R8 R9 R10: an expiry is only ever the end of an armed interval
    a_r9_expiry_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(armed));

endmodule

// File: rtl/desc_accumulator.sv
module desc_accumulator
    import desc_acc_pkg::*;
#(
    parameter int NUM_Q       = 32,
    parameter int DESC_W      = 32,
    parameter int LIST_DEPTH  = 16,
    parameter int QNUM_W      = 14,
    parameter int DLY_W       = 16,
    parameter int TICK_CYCLES = 100,
    localparam int IDX_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int CNT_W  = $clog2(LIST_DEPTH + 1),
    localparam int LIDX_W = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1,
    localparam int ENT_W  = IDX_W + DESC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QNUM_W-1:0] cfg_base_q,
    input  logic [1:0]        cfg_mode,
    input  logic [DLY_W-1:0]  cfg_delay_us,
    input  logic [NUM_Q-1:0]  q_nonempty,
    output logic              pop_req,
    output logic [QNUM_W-1:0] pop_qnum,
    input  logic              pop_ack,
    input  logic [DESC_W-1:0] pop_desc,
    output logic              lw_en,
    output logic              lw_buf,
    output logic [LIDX_W-1:0] lw_idx,
    output logic [ENT_W-1:0]  lw_data,
    output logic              irq,
    output logic              irq_buf,
    output logic [CNT_W-1:0]  irq_cnt,
    input  logic              irq_ack
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(LIST_DEPTH);
    localparam logic [IDX_W-1:0] LAST_Q   = IDX_W'(NUM_Q - 1);

    acc_state_e       state, state_nx;
    pace_mode_e       mode;
    logic [IDX_W-1:0] sel_q, rr_ptr, pick;
    logic             found;
    logic [CNT_W-1:0] count;
    logic             cur_buf, pending;
    logic             full, wr, hand;
    logic             t_start, t_armed, t_expired;

    assign mode = pace_mode_e'(cfg_mode);
    assign full = (count == FULL_CNT);
    assign wr   = (state == ST_POP) && pop_ack;
    assign hand = !wr && (count != '0) && !pending &&
                  (full || ((mode != PACE_FULL_ONLY) && t_expired));

    desc_acc_rr #(.N(NUM_Q), .W(IDX_W)) u_rr (
        .req   (q_nonempty),
        .ptr   (rr_ptr),
        .found (found),
        .pick  (pick)
    );

    always_comb begin
        unique case (mode)
            PACE_SINCE_IRQ:   t_start = hand || (!t_armed && !t_expired);
            PACE_SINCE_FIRST: t_start = wr && (count == '0);
            PACE_SINCE_LAST:  t_start = wr;
            default:          t_start = 1'b0;
        endcase
    end

    desc_acc_pacer #(.TICK_CYCLES(TICK_CYCLES), .DLY_W(DLY_W)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (t_start),
        .stop    (hand),
        .delay   (cfg_delay_us),
        .armed   (t_armed),
        .expired (t_expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SCAN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SCAN: begin
                if (full)       state_nx = ST_STALL;
                else if (found) state_nx = ST_POP;
            end
            ST_POP:   if (pop_ack) state_nx = ST_SCAN;
            ST_STALL: if (!full)   state_nx = ST_SCAN;
            default:  state_nx = ST_SCAN;
        endcase
    end

    // Outputs
    always_comb begin
        pop_req  = (state == ST_POP);
        pop_qnum = cfg_base_q + QNUM_W'(sel_q);
        irq      = pending;
    end

    // Datapath: selection, list writes, hand-over
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            rr_ptr  <= '0;
            count   <= '0;
            cur_buf <= 1'b0;
            pending <= 1'b0;
            irq_buf <= 1'b0;
            irq_cnt <= '0;
            lw_en   <= 1'b0;
            lw_buf  <= 1'b0;
            lw_idx  <= '0;
            lw_data <= '0;
        end else begin
            lw_en <= wr;
            if ((state == ST_SCAN) && found && !full) begin
                sel_q <= pick;
            end
            if (wr) begin
                lw_buf  <= cur_buf;
                lw_idx  <= count[LIDX_W-1:0];
                lw_data <= {sel_q, pop_desc};
                count   <= count + 1'b1;
                rr_ptr  <= (sel_q == LAST_Q) ? '0 : sel_q + 1'b1;
            end
            if (hand) begin
                pending <= 1'b1;
                irq_buf <= cur_buf;
                irq_cnt <= count;
                cur_buf <= ~cur_buf;
                count   <= '0;
            end else if (pending && irq_ack) begin
                pending <= 1'b0;
            end
        end
    end

    a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !pop_ack) |=> (pop_req && $stable(pop_qnum)));

    a_r3_no_write_past_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && pop_ack) |-> (count < FULL_CNT));

    a_r4_irq_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (irq_cnt != '0));

    a_r5_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> (irq && $stable(irq_buf) && $stable(irq_cnt)));

    a_r6_stall_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && pending) |-> !pop_req);

    a_r7_mode0_full_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && (cfg_mode == 2'd0)) |-> (irq_cnt == FULL_CNT));

endmodule

// File: tb/tb_desc_accumulator.sv
`timescale 1ns/1ps
module tb_desc_accumulator;

    localparam int NQ    = 32;
    localparam int DEPTH = 16;
    localparam int TICK  = 4;
    localparam int DLY   = 5;
    localparam int PACE  = DLY * TICK + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] cfg_base_q = '0;
    logic [1:0]  cfg_mode = '0;
    logic [15:0] cfg_delay_us = '0;
    logic [NQ-1:0] q_nonempty;
    logic        pop_req, pop_ack = 1'b0;
    logic [13:0] pop_qnum;
    logic [31:0] pop_desc = '0;
    logic        lw_en, lw_buf, irq, irq_buf, irq_ack = 1'b0;
    logic [3:0]  lw_idx;
    logic [36:0] lw_data;
    logic [4:0]  irq_cnt;

    always #5 clk = ~clk;

    desc_accumulator #(.TICK_CYCLES(TICK)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_base_q(cfg_base_q), .cfg_mode(cfg_mode),
        .cfg_delay_us(cfg_delay_us), .q_nonempty(q_nonempty), .pop_req(pop_req),
        .pop_qnum(pop_qnum), .pop_ack(pop_ack), .pop_desc(pop_desc), .lw_en(lw_en),
        .lw_buf(lw_buf), .lw_idx(lw_idx), .lw_data(lw_data), .irq(irq),
        .irq_buf(irq_buf), .irq_cnt(irq_cnt), .irq_ack(irq_ack)
    );

    // Queue model state (written only by the monitor process)
    int qcnt [NQ];
    int exp_q [4096];
    int exp_d [4096];
    int popseq [64];
    int fwr, frd, npop, serial;
    int cyc, wcnt, exp_buf, lw_total, irq_rises, irq_sum;
    int last_lw_cyc, first_lw_cyc, last_irq_cyc;
    int ack_wait, irq_wait, ld_seen;
    int mchecks, merrs;
    logic irq_d, rst_d, wait_prev;
    logic [13:0] prev_qnum;

    // Controls written only by the directed process
    int ld_seq, ld_q, ld_n;
    int pop_lat_max, irq_lat_max;
    logic ack_en;
    int dchecks, derrs;

    initial begin
        ld_seq = 0; ld_q = 0; ld_n = 0; pop_lat_max = 0; irq_lat_max = 0;
        ack_en = 1'b1; dchecks = 0; derrs = 0;
    end

    always_comb begin
        for (int i = 0; i < NQ; i++) q_nonempty[i] = (qcnt[i] != 0);
    end

    initial begin
        for (int i = 0; i < NQ; i++) qcnt[i] = 0;
        fwr = 0; frd = 0; npop = 0; serial = 0; cyc = 0; wcnt = 0; exp_buf = 0;
        lw_total = 0; irq_rises = 0; irq_sum = 0; last_lw_cyc = 0; first_lw_cyc = 0;
        last_irq_cyc = 0; ack_wait = 0; irq_wait = 0; ld_seen = 0;
        mchecks = 0; merrs = 0; irq_d = 1'b0; rst_d = 1'b1; wait_prev = 1'b0; prev_qnum = '0;
    end

    // Monitor, pop responder and host model, all at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            if (rst_d) begin
                for (int i = 0; i < NQ; i++) qcnt[i] = 0;
                fwr = 0; frd = 0; npop = 0; cyc = 0; wcnt = 0; exp_buf = 0;
                lw_total = 0; irq_rises = 0; irq_sum = 0; ack_wait = 0; irq_wait = 0;
                irq_d = 1'b0; wait_prev = 1'b0;
            end
            rst_d = 1'b0;
            pop_ack = 1'b0;
            irq_ack = 1'b0;
        end else begin
            rst_d = 1'b1;
            cyc++;
            // R4: hand-over contents
            if (irq && !irq_d) begin
                irq_rises++;
                last_irq_cyc = cyc;
                mchecks++;
                if (int'(irq_buf) != exp_buf || int'(irq_cnt) != wcnt) begin
                    merrs++;
                    $display("FAIL R4: irq buf/cnt act %0d/%0d exp %0d/%0d",
                             irq_buf, irq_cnt, exp_buf, wcnt);
                end
                irq_sum += int'(irq_cnt);
                exp_buf ^= 1;
                wcnt = 0;
                irq_wait = (irq_lat_max == 0) ? 0 : int'($urandom % (irq_lat_max + 1));
            end
            irq_d = irq;
            // R3: list entry contents
            if (lw_en) begin
                mchecks++;
                if (frd == fwr) begin
                    merrs++;
                    $display("FAIL R3: list write with no pop, act %h exp none", lw_data);
                end else begin
                    if (lw_data !== {exp_q[frd][4:0], exp_d[frd][31:0]} ||
                        int'(lw_buf) != exp_buf || int'(lw_idx) != wcnt) begin
                        merrs++;
                        $display("FAIL R3: entry act %h b%0d i%0d exp %h b%0d i%0d",
                                 lw_data, lw_buf, lw_idx,
                                 {exp_q[frd][4:0], exp_d[frd][31:0]}, exp_buf, wcnt);
                    end
                    frd++;
                end
                if (lw_total == 0) first_lw_cyc = cyc;
                last_lw_cyc = cyc;
                wcnt++;
                lw_total++;
            end
            // R2: pop handshake
            if (wait_prev) begin
                mchecks++;
                if (!pop_req || pop_qnum != prev_qnum) begin
                    merrs++;
                    $display("FAIL R2: request dropped/changed act %0d/%0d exp 1/%0d",
                             pop_req, pop_qnum, prev_qnum);
                end
            end
            pop_ack = 1'b0;
            if (pop_req) begin
                int q;
                q = int'(pop_qnum) - int'(cfg_base_q);
                if (q < 0 || q >= NQ || qcnt[(q < 0 || q >= NQ) ? 0 : q] == 0) begin
                    mchecks++;
                    merrs++;
                    $display("FAIL R2: pop of empty/outside queue act %0d exp nonempty", q);
                end else if (ack_wait == 0) begin
                    pop_ack = 1'b1;
                    serial++;
                    pop_desc = {q[7:0], serial[23:0]};
                    exp_q[fwr] = q;
                    exp_d[fwr] = int'(pop_desc);
                    fwr++;
                    qcnt[q]--;
                    if (npop < 64) popseq[npop] = q;
                    npop++;
                    ack_wait = (pop_lat_max == 0) ? 0 : int'($urandom % (pop_lat_max + 1));
                end else begin
                    ack_wait--;
                end
            end
            wait_prev = pop_req && !pop_ack;
            prev_qnum = pop_qnum;
            // Host acknowledge
            if (irq_ack) begin
                irq_ack = 1'b0;
            end else if (irq && ack_en) begin
                if (irq_wait == 0) irq_ack = 1'b1;
                else irq_wait--;
            end
        end
        if (ld_seq != ld_seen) begin
            qcnt[ld_q] += ld_n;
            ld_seen = ld_seq;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic load(input int q, input int n);
        ld_q = q;
        ld_n = n;
        ld_seq++;
        tick();
    endtask

    task automatic begin_test(input int m, input int d, input int b);
        rst_n = 1'b0;
        cfg_mode = 2'(m);
        cfg_delay_us = 16'(d);
        cfg_base_q = 14'(b);
        tick();
        tick();
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        dchecks++;
        if (!ok) begin
            derrs++;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: act timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors",
                 mchecks + dchecks + 1, merrs + derrs + 1);
        $finish;
    end

    initial begin
        int t1, total;
        void'($urandom(32'd20240611));

        // R1: reset state
        begin_test(0, DLY, 0);
        chk(!irq && !pop_req && !lw_en, "R1", int'({irq, pop_req, lw_en}), 0);
        rst_n = 1'b1;
        tick();
        chk(!irq && !pop_req && !lw_en, "R1", int'({irq, pop_req, lw_en}), 0);
        repeat (20) tick();
        chk(!pop_req && lw_total == 0, "R2 idle", lw_total, 0);

        // R2: round-robin with a base offset
        begin_test(0, DLY, 100);
        pop_lat_max = 2;
        load(3, 2); load(7, 2); load(30, 2);
        rst_n = 1'b1;
        repeat (80) tick();
        chk(npop == 6, "R2 pops", npop, 6);
        chk(popseq[0] == 3 && popseq[1] == 7 && popseq[2] == 30, "R2 order a", popseq[1], 7);
        chk(popseq[3] == 3 && popseq[4] == 7 && popseq[5] == 30, "R2 order b", popseq[4], 7);
        chk(lw_total == 6 && !irq, "R7 partial list kept", lw_total, 6);

        // R4 R5 R6 R7: fill both buffers with no acknowledge
        begin_test(0, DLY, 0);
        pop_lat_max = 0;
        ack_en = 1'b0;
        load(0, 40);
        rst_n = 1'b1;
        repeat (300) tick();
        chk(lw_total == 2 * DEPTH, "R6 writes before stall", lw_total, 2 * DEPTH);
        chk(irq && irq_buf == 1'b0, "R5 irq held buf0", int'({irq, irq_buf}), 2);
        chk(int'(irq_cnt) == DEPTH, "R4 irq_cnt full", int'(irq_cnt), DEPTH);
        chk(!pop_req, "R6 no pop while stalled", int'(pop_req), 0);
        repeat (50) tick();
        chk(lw_total == 2 * DEPTH && irq_rises == 1, "R6 still stalled", lw_total, 2 * DEPTH);
        ack_en = 1'b1;
        repeat (300) tick();
        chk(lw_total == 40, "R6 resumed", lw_total, 40);
        chk(irq_rises == 2, "R6 held list handed over", irq_rises, 2);
        chk(!irq && wcnt == 8, "R7 residue not handed over", wcnt, 8);

        // R8: mode 1
        begin_test(1, DLY, 0);
        rst_n = 1'b1;
        repeat (80) tick();
        chk(irq_rises == 0, "R8 empty expiry", irq_rises, 0);
        load(2, 1);
        for (int k = 0; k < 100 && irq_rises < 1; k++) tick();
        chk(last_irq_cyc - last_lw_cyc == 1, "R8 late entry", last_irq_cyc - last_lw_cyc, 1);
        t1 = last_irq_cyc;
        load(4, 1);
        for (int k = 0; k < 200 && irq_rises < 2; k++) tick();
        chk(last_irq_cyc - t1 == PACE, "R8 since irq", last_irq_cyc - t1, PACE);

        // R9: mode 2
        begin_test(2, DLY, 0);
        rst_n = 1'b1;
        load(1, 1);
        for (int k = 0; k < 50 && lw_total < 1; k++) tick();
        repeat (8) tick();
        load(9, 1);
        for (int k = 0; k < 200 && irq_rises < 1; k++) tick();
        chk(last_irq_cyc - first_lw_cyc == PACE, "R9 since first",
            last_irq_cyc - first_lw_cyc, PACE);
        chk(irq_sum == 2, "R9 count", irq_sum, 2);

        // R10: mode 3
        begin_test(3, DLY, 0);
        rst_n = 1'b1;
        load(1, 1);
        for (int k = 0; k < 50 && lw_total < 1; k++) tick();
        repeat (8) tick();
        load(9, 1);
        for (int k = 0; k < 200 && irq_rises < 1; k++) tick();
        chk(last_irq_cyc - last_lw_cyc == PACE, "R10 since last",
            last_irq_cyc - last_lw_cyc, PACE);
        chk(last_lw_cyc > first_lw_cyc && irq_sum == 2, "R10 count", irq_sum, 2);

        // R3 R4: random traffic in the timed modes
        for (int m = 1; m <= 3; m++) begin
            begin_test(m, 3, 37);
            pop_lat_max = 3;
            irq_lat_max = 15;
            total = 0;
            for (int j = 0; j < 10; j++) begin
                int q, n;
                q = int'($urandom % NQ);
                n = 1 + int'($urandom % 30);
                total += n;
                load(q, n);
            end
            rst_n = 1'b1;
            for (int k = 0; k < 20000 && (irq_sum < total || irq); k++) tick();
            chk(lw_total == total, "R3 random writes", lw_total, total);
            chk(irq_sum == total, "R4 random hand-over", irq_sum, total);
        end

        $display("Simulation finished: %0d checks, %0d errors",
                 mchecks + dchecks, merrs + derrs);
        $finish;
    end

endmodule